// File: doc/BRIEF.md
# Keyhole Video Memory Access Port

This block is a small write-only register window placed in the address space of an 8-bit host processor. Through it the host reaches a video memory far larger than its own 64 KiB space. The host first writes three address registers (segment, page and offset), which together form a 20-bit target pointer. It then writes bytes to a data register. Each data write is forwarded to the wide memory at the current pointer, and the pointer then steps forward by one. A bitmap can therefore be streamed with one host store per byte and no further address updates.

The pointer steps like one 20-bit counter. An offset overflow carries into the page, a page overflow carries into the segment, and the segment wraps to zero after its top value. The memory side is a simple synchronous write port: a one-clock strobe with address and data. The live pointer is also brought out, so the loaded and incremented address can be seen. Only host write cycles are decoded. Host reads do not reach the block.

Top module: `keyhole_port`

## Requirements
- R1: While reset is held and just after it is released, `curAddr`, `memAddr` and `memData` are zero and `memWrEn` is low.
- R2: A host write to register index 0 (segment) loads `hostData[3:0]` into `curAddr[19:16]` on the next clock. `curAddr[15:0]` is unchanged and `hostData[7:4]` is discarded.
- R3: A host write to register index 1 (page) loads `hostData` into `curAddr[15:8]` on the next clock. The other pointer bits are unchanged.
- R4: A host write to register index 2 (offset) loads `hostData` into `curAddr[7:0]` on the next clock. The other pointer bits are unchanged.
- R5: A host write to register index 3 (data) raises `memWrEn` on the next clock for exactly one clock per write. During that clock `memAddr` holds the pointer value from before the write and `memData` holds the written byte.
- R6: After each data write, `curAddr` on the next clock equals the previous pointer plus one. Offset overflow carries into the page and page overflow carries into the segment.
- R7: A data write at pointer 0xFFFFF stores at 0xFFFFF, and the pointer wraps to 0x00000.
- R8: Writes to the segment, page or offset registers never raise `memWrEn`.
- R9: While `hostWrEn` is low, the pointer does not change and `memWrEn` stays low, whatever `hostAddr` and `hostData` hold.
- R10: Data writes on consecutive clocks each produce a strobe, and the strobes go to consecutive addresses with no gap clock.
- R11: Host writes to register indices 4 to 15 change neither the pointer nor `memWrEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostWrEn | input | 1 | Host write cycle to the window, one clock per write |
| hostAddr | input | 4 | Register index within the window |
| hostData | input | 8 | Host write data |
| curAddr | output | 20 | Live target pointer {segment, page, offset} |
| memWrEn | output | 1 | Video memory write strobe |
| memAddr | output | 20 | Video memory write address |
| memData | output | 8 | Video memory write data |

## Verification
The assertions assume that the host presents at most one register write per clock and that `hostAddr` and `hostData` are stable around the sampling edge whenever `hostWrEn` is high. They also assume the inputs are quiet while reset is held, so that the first comparison against the previous cycle sees a zeroed pointer. The bench drives every input on the falling clock edge and keeps `hostWrEn` low during reset. It also places all address-register loads and data streams on distinct clocks, so each assertion's precondition comes from exactly one host action.

// File: rtl/keyhole_pkg.sv
package keyhole_pkg;

  // Register indices inside the host window; the datapath relies on this order.
  typedef enum logic [1:0] {
    REG_SEG  = 2'd0,
    REG_PAGE = 2'd1,
    REG_OFS  = 2'd2,
    REG_DATA = 2'd3
  } khReg_e;

  // Strobes from the decode control to the pointer datapath.
  typedef struct packed {
    logic loadSeg;
    logic loadPage;
    logic loadOfs;
    logic storeByte;
  } khStrobes_t;

endpackage

// File: rtl/keyhole_ctrl.sv
module keyhole_ctrl
  import keyhole_pkg::*;
#(
  parameter int HOST_AW = 4
) (
  input  logic               hostWrEn,
  input  logic [HOST_AW-1:0] hostAddr,
  output khStrobes_t         strobes
);

  logic   inWindow;
  khReg_e regSel;

  // Only the four lowest indices are registers; the rest of the window is ignored.
  generate
    if (HOST_AW > 2) begin : g_upperDecode
      assign inWindow = (hostAddr[HOST_AW-1:2] == '0);
    end else begin : g_fullDecode
      assign inWindow = 1'b1;
    end
  endgenerate

  assign regSel = khReg_e'(hostAddr[1:0]);

  always_comb begin
    strobes = '0;
    if (hostWrEn && inWindow) begin
      unique case (regSel)
        REG_SEG:  strobes.loadSeg   = 1'b1;
        REG_PAGE: strobes.loadPage  = 1'b1;
        REG_OFS:  strobes.loadOfs   = 1'b1;
        REG_DATA: strobes.storeByte = 1'b1;
      endcase
    end
  end

  // At most one action per host write
  always_comb begin
    AST_ONE_ACTION: assert ($countones(strobes) <= 1 || !hostWrEn) // R11
      else $error("more than one strobe raised for a single host write");
  end

endmodule

// File: rtl/keyhole_dp.sv
module keyhole_dp
  import keyhole_pkg::*;
#(
  parameter int SEG_W  = 4,
  parameter int PAGE_W = 8,
  parameter int OFS_W  = 8,
  parameter int DATA_W = 8,
  localparam int ADDR_W = SEG_W + PAGE_W + OFS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  khStrobes_t        strobes,
  input  logic [DATA_W-1:0] hostData,
  output logic [ADDR_W-1:0] curAddr,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData
);

  logic [SEG_W-1:0]  segQ;
  logic [PAGE_W-1:0] pageQ;
  logic [OFS_W-1:0]  ofsQ;

  // Explicit carry chain across the three fields
  logic ofsCarry;
  logic pageCarry;

  assign ofsCarry  = &ofsQ;
  assign pageCarry = ofsCarry & (&pageQ);

  assign curAddr = {segQ, pageQ, ofsQ};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      segQ  <= '0;
      pageQ <= '0;
      ofsQ  <= '0;
    end else if (strobes.storeByte) begin
      ofsQ <= ofsQ + OFS_W'(1);
      if (ofsCarry)  pageQ <= pageQ + PAGE_W'(1);
      if (pageCarry) segQ  <= segQ + SEG_W'(1);
    end else begin
      if (strobes.loadSeg)  segQ  <= hostData[SEG_W-1:0];
      if (strobes.loadPage) pageQ <= hostData[PAGE_W-1:0];
      if (strobes.loadOfs)  ofsQ  <= hostData[OFS_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memWrEn <= 1'b0;
      memAddr <= '0;
      memData <= '0;
    end else begin
      memWrEn <= strobes.storeByte;
      if (strobes.storeByte) begin
        memAddr <= curAddr;
        memData <= hostData;
      end
    end
  end

  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.storeByte && !strobes.loadPage) |=> $stable(pageQ)) // R6
    else $error("page field moved without a store or page load");

  AST_SEG_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.loadSeg && !(strobes.storeByte && pageCarry)) |=> $stable(segQ)) // R6
    else $error("segment field moved without carry or load");

endmodule

// File: rtl/keyhole_port.sv
module keyhole_port
  import keyhole_pkg::*;
#(
  parameter int HOST_AW = 4,
  parameter int SEG_W   = 4,
  parameter int PAGE_W  = 8,
  parameter int OFS_W   = 8,
  parameter int DATA_W  = 8,
  localparam int ADDR_W = SEG_W + PAGE_W + OFS_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWrEn,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [DATA_W-1:0]  hostData,
  output logic [ADDR_W-1:0]  curAddr,
  output logic               memWrEn,
  output logic [ADDR_W-1:0]  memAddr,
  output logic [DATA_W-1:0]  memData
);

  khStrobes_t strobes;

  keyhole_ctrl #(.HOST_AW(HOST_AW)) ctrl_i (
    .hostWrEn(hostWrEn),
    .hostAddr(hostAddr),
    .strobes (strobes)
  );

  keyhole_dp #(
    .SEG_W (SEG_W),
    .PAGE_W(PAGE_W),
    .OFS_W (OFS_W),
    .DATA_W(DATA_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .hostData(hostData),
    .curAddr (curAddr),
    .memWrEn (memWrEn),
    .memAddr (memAddr),
    .memData (memData)
  );

  logic dataWr;
  logic segWr;
  logic highWr;
  assign dataWr = hostWrEn && (hostAddr == HOST_AW'(3));
  assign segWr  = hostWrEn && (hostAddr == HOST_AW'(0));
  assign highWr = hostWrEn && (hostAddr > HOST_AW'(3));

  AST_STORE_PORT: assert property (@(posedge clk) disable iff (!rstN)
    dataWr |=> (memWrEn && memAddr == $past(curAddr) && memData == $past(hostData))) // R5
    else $error("data write not forwarded correctly");

  AST_NO_SPURIOUS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !dataWr |=> !memWrEn) // R8
    else $error("strobe without a data write");

  AST_AUTO_STEP: assert property (@(posedge clk) disable iff (!rstN)
    dataWr |=> (curAddr == $past(curAddr) + ADDR_W'(1))) // R6
    else $error("pointer did not step by one");

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !hostWrEn |=> $stable(curAddr)) // R9
    else $error("pointer moved with no host write");

  AST_HIGH_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    highWr |=> ($stable(curAddr) && !memWrEn)) // R11
    else $error("write outside register window had an effect");

  AST_SEG_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    segWr |=> (curAddr[ADDR_W-1:ADDR_W-SEG_W] == $past(hostData[SEG_W-1:0])
               && curAddr[ADDR_W-SEG_W-1:0] == $past(curAddr[ADDR_W-SEG_W-1:0]))) // R2
    else $error("segment load wrong");

endmodule

// File: tb/keyhole_port_tb_top.sv
`timescale 1ns/1ps
module keyhole_port_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0;
  logic [3:0]  hostAddr = '0;
  logic [7:0]  hostData = '0;
  logic [19:0] curAddr;
  logic        memWrEn;
  logic [19:0] memAddr;
  logic [7:0]  memData;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [19:0] expAddr;

  always #4 clk = ~clk;

  keyhole_port dut_i (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostData(hostData), .curAddr(curAddr), .memWrEn(memWrEn),
    .memAddr(memAddr), .memData(memData)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // One host write; returns at the negedge after the sampling edge
  task automatic hostWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = a; hostData = d;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic setPtr(input logic [19:0] p);
    hostWrite(4'd0, {4'hC, p[19:16]});
    hostWrite(4'd1, p[15:8]);
    hostWrite(4'd2, p[7:0]);
    expAddr = p;
  endtask

  // Back-to-back data stream of n bytes starting at the current pointer
  task automatic streamBytes(input int n, input int seed);
    logic [7:0] b;
    @(negedge clk);
    b = 8'((seed * 7 + 3) & 8'hFF);
    hostWrEn = 1'b1; hostAddr = 4'd3; hostData = b;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(memWrEn == 1'b1, "R10 strobe", 32'(memWrEn), 32'd1);
      chk(memAddr == expAddr, "R5 write address", 32'(memAddr), 32'(expAddr));
      chk(memData == b, "R5 write data", 32'(memData), 32'(b));
      expAddr = expAddr + 20'd1;
      chk(curAddr == expAddr, "R6 pointer step", 32'(curAddr), 32'(expAddr));
      if (i < n - 1) begin
        b = 8'(((seed + i + 1) * 7 + 3) & 8'hFF);
        hostData = b;
      end else begin
        hostWrEn = 1'b0;
      end
    end
    @(negedge clk);
    chk(memWrEn == 1'b0, "R5 single clock strobe", 32'(memWrEn), 32'd0);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(curAddr == 20'd0 && memWrEn == 1'b0 && memAddr == 20'd0 && memData == 8'd0,
        "R1 reset state", 32'(curAddr), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(curAddr == 20'd0 && memWrEn == 1'b0, "R1 after release", 32'(curAddr), 32'd0);
    expAddr = '0;

    // Segment sweep with junk upper nibble
    for (int s = 0; s < 16; s++) begin
      hostWrite(4'd0, 8'((s * 16 + 5) & 8'hF0) | 8'(s));
      expAddr[19:16] = 4'(s);
      chk(curAddr == expAddr, "R2 segment load", 32'(curAddr), 32'(expAddr));
      chk(memWrEn == 1'b0, "R8 no strobe on segment", 32'(memWrEn), 32'd0);
    end
    // Page sweep
    for (int p = 0; p < 256; p++) begin
      hostWrite(4'd1, 8'(p));
      expAddr[15:8] = 8'(p);
      chk(curAddr == expAddr, "R3 page load", 32'(curAddr), 32'(expAddr));
      chk(memWrEn == 1'b0, "R8 no strobe on page", 32'(memWrEn), 32'd0);
    end
    // Offset sweep
    for (int o = 0; o < 256; o++) begin
      hostWrite(4'd2, 8'(o ^ 8'h5A));
      expAddr[7:0] = 8'(o ^ 8'h5A);
      chk(curAddr == expAddr, "R4 offset load", 32'(curAddr), 32'(expAddr));
      chk(memWrEn == 1'b0, "R8 no strobe on offset", 32'(memWrEn), 32'd0);
    end

    // Indices outside the window
    setPtr(20'h5A3C1);
    for (int a = 4; a < 16; a++) begin
      hostWrite(4'(a), 8'hFF);
      chk(curAddr == expAddr, "R11 high index ignored", 32'(curAddr), 32'(expAddr));
      chk(memWrEn == 1'b0, "R11 high index no strobe", 32'(memWrEn), 32'd0);
    end

    // Host bus idle but address/data toggling
    for (int a = 0; a < 4; a++) begin
      @(negedge clk);
      hostWrEn = 1'b0; hostAddr = 4'(a); hostData = 8'(a * 37);
      @(negedge clk);
      chk(curAddr == expAddr, "R9 idle pointer", 32'(curAddr), 32'(expAddr));
      chk(memWrEn == 1'b0, "R9 idle no strobe", 32'(memWrEn), 32'd0);
    end

    // Isolated single writes with gaps
    for (int k = 0; k < 4; k++) begin
      hostWrite(4'd3, 8'(k + 8'h80));
      chk(memWrEn == 1'b1 && memAddr == expAddr && memData == 8'(k + 8'h80),
          "R5 single write", 32'(memAddr), 32'(expAddr));
      expAddr = expAddr + 20'd1;
      chk(curAddr == expAddr, "R6 single step", 32'(curAddr), 32'(expAddr));
      @(negedge clk);
      chk(memWrEn == 1'b0, "R5 strobe one clock", 32'(memWrEn), 32'd0);
    end

    // Long stream crossing page and segment boundaries
    setPtr(20'h3FFF0);
    streamBytes(600, 11);
    setPtr(20'h0F0FE);
    streamBytes(300, 40);

    // Full wrap of the pointer
    setPtr(20'hFFFFE);
    streamBytes(3, 99);
    chk(curAddr == 20'h00001, "R7 wrap to zero", 32'(curAddr), 32'h00001);

    done = 1'b1;
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=done", checks);
      summary();
    end
  end

endmodule